// File: doc/BRIEF.md
# Speculative Load Fault Screener

This block screens a speculative load before the load unit runs it. A load of this kind must never trap. Any fault it would raise is parked on the destination register as a deferred-fault tag, and a later consumer or commit point acts on that tag. The block forms the effective address as a base value plus either an index value or an immediate. It tests the address and the destination register number against the access size, and it updates one of two 64-bit tag vectors, one for integer registers and one for floating-point registers. It then reports whether the load may go ahead.

A request is accepted only while the block is idle. A four-state machine then walks it through a fixed sequence. ST_IDLE accepts the request and latches the operands, then moves to ST_EVAL. ST_EVAL registers the address, the fault findings and the source-tag lookup, then moves to ST_UPDATE. ST_UPDATE writes the tag vector and the optional log entry, then moves to ST_RESP. ST_RESP presents `done` for exactly one cycle, then returns to ST_IDLE.

When the configuration is marked valid and logging is switched on, every screened load is also recorded in a small table of status slots. Each slot has a companion address register. A recorded slot stays occupied until it is released. If no slot is free, an error flag is raised and no existing slot is overwritten.

Top module: `spec_load_guard`

## Requirements
- R1: The effective address is `req_base_val + req_idx_val` when `req_idx_en` is 1, and `req_base_val + req_imm` otherwise. The sum wraps modulo 2^32.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word, 3 = doubleword and 4 = quadword. A memory-alignment fault occurs when the low 0, 1, 2, 3 or 4 address bits respectively are not all zero. Codes 5 to 7 never fault.
- R3: A register-alignment fault occurs for a doubleword whose destination number is odd, and for a quadword whose destination number is not a multiple of 4.
- R4: On any alignment fault, the destination's tag is set and `proceed` is 1.
- R5: With no fault, if the tag of the base register is set (or the tag of the index register, when `req_idx_en` is 1), the destination tag is set and `proceed` is 0. Otherwise the destination tag is cleared and `proceed` is 1. The index register's tag is ignored when `req_idx_en` is 0.
- R6: When `req_float` is 1, source lookups and the destination update use `fr_ne`. When it is 0, they use `gr_ne`. The other vector is left unchanged.
- R7: A log entry is written only when `cfg_valid` and `cfg_log_en` are both 1. The entry holds: valid, address-valid, the destination number, the size code, its own slot number as a tag, the float flag, a register-alignment error bit and a memory-alignment error bit. The slot's address register holds the effective address.
- R8: The slot written is the lowest-numbered slot below `cfg_slots` whose valid bit is clear. If logging is on and no such slot exists, `log_err` is 1 in the response cycle and every slot is left as it was.
- R9: A one-cycle pulse on `rel_valid` clears the valid bit of slot `rel_slot`, which makes it free for later allocation.
- R10: After reset, both tag vectors are zero, every slot is invalid, `req_ready` is 1 and `done` is 0. `done` rises on the third falling edge after the request is accepted, lasts one cycle, and `req_ready` is 0 while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_base_sel | input | 6 | Base register number |
| req_base_val | input | 32 | Base register value |
| req_idx_en | input | 1 | Use the index register instead of the immediate |
| req_idx_sel | input | 6 | Index register number |
| req_idx_val | input | 32 | Index register value |
| req_imm | input | 32 | Immediate displacement |
| req_size | input | 3 | Access size code |
| req_dst | input | 6 | Destination register number |
| req_float | input | 1 | Destination is floating-point |
| cfg_valid | input | 1 | Configuration valid |
| cfg_log_en | input | 1 | Logging enable |
| cfg_slots | input | 3 | Implemented slot count |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 2 | Slot to release |
| rd_slot | input | 2 | Slot selected for readout |
| done | output | 1 | Response cycle |
| proceed | output | 1 | Load may execute |
| log_err | output | 1 | Logging wanted but no slot free |
| gr_ne | output | 64 | Integer deferred-fault tags |
| fr_ne | output | 64 | Floating-point deferred-fault tags |
| rd_valid | output | 1 | Selected slot valid |
| rd_addr_valid | output | 1 | Selected slot address valid |
| rd_dst | output | 6 | Selected slot destination |
| rd_size | output | 3 | Selected slot size code |
| rd_tag | output | 2 | Selected slot self index |
| rd_float | output | 1 | Selected slot float flag |
| rd_reg_err | output | 1 | Selected slot register-alignment error |
| rd_mem_err | output | 1 | Selected slot memory-alignment error |
| rd_addr | output | 32 | Selected slot effective address |

## Verification
The bench targets the boundaries of each alignment test: an odd halfword, a word two bytes off, a doubleword to an odd register, a quadword to a register that is even but not a multiple of 4, and bit 63 of the tag vector. A design with a miscounted mask would either pass these cases or fault on aligned ones. The bench probes source-tag propagation with the index register both enabled and disabled. A design that always reads the index tag would wrongly suppress a load. The bench also routes floating-point traffic through the tags, so that any crossing between the two vectors shows up. On the log side, the bench shrinks the slot count until the table is full and then releases a middle slot. A design that overwrote entries, or that ignored the count or the lowest-free rule, would then place an entry in the wrong slot or fail to raise the error.

// File: rtl/slg_pkg.sv
package slg_pkg;
    localparam logic [2:0] SZ_BYTE  = 3'd0;
    localparam logic [2:0] SZ_HALF  = 3'd1;
    localparam logic [2:0] SZ_WORD  = 3'd2;
    localparam logic [2:0] SZ_DWORD = 3'd3;
    localparam logic [2:0] SZ_QUAD  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_UPDATE,
        ST_RESP
    } state_t;
endpackage

// File: rtl/slg_addr_check.sv
module slg_addr_check
    import slg_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 6
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] imm,
    input  logic          idx_en,
    input  logic [2:0]    size,
    input  logic [RW-1:0] dst,
    output logic [AW-1:0] addr,
    output logic          mem_fault,
    output logic          reg_fault
);
    always_comb begin
        addr = base_val + (idx_en ? idx_val : imm);
    end

    always_comb begin
        mem_fault = 1'b0;
        reg_fault = 1'b0;
        unique case (size)
            SZ_HALF:  mem_fault = addr[0];
            SZ_WORD:  mem_fault = |addr[1:0];
            SZ_DWORD: begin
                mem_fault = |addr[2:0];
                reg_fault = dst[0];
            end
            SZ_QUAD: begin
                mem_fault = |addr[3:0];
                reg_fault = |dst[1:0];
            end
            default: begin
                mem_fault = 1'b0;
                reg_fault = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slg_ne_flags.sv
module slg_ne_flags #(
    parameter int NREG = 64,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_float,
    input  logic [RW-1:0]   q_a,
    input  logic [RW-1:0]   q_b,
    input  logic            q_b_en,
    output logic            src_flag,
    input  logic            upd_en,
    input  logic            upd_float,
    input  logic [RW-1:0]   upd_idx,
    input  logic            upd_val,
    output logic [NREG-1:0] gr_vec,
    output logic [NREG-1:0] fr_vec
);
    logic [NREG-1:0] sel_vec;

    always_comb begin
        sel_vec  = q_float ? fr_vec : gr_vec;
        src_flag = sel_vec[q_a] | (q_b_en & sel_vec[q_b]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gr_vec <= '0;
            fr_vec <= '0;
        end else if (upd_en) begin
            if (upd_float) fr_vec[upd_idx] <= upd_val;
            else           gr_vec[upd_idx] <= upd_val;
        end
    end

    // R5: the written tag takes the requested value
    a_r5_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (($past(upd_float) ? fr_vec[$past(upd_idx)] : gr_vec[$past(upd_idx)]) == $past(upd_val)));

    // R6: an integer update leaves the float vector alone
    a_r6_fr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_float) |=> $stable(fr_vec));

    // R6: a float update leaves the integer vector alone
    a_r6_gr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_float) |=> $stable(gr_vec));
endmodule

// File: rtl/slg_log_table.sv
module slg_log_table #(
    parameter int SLOTS = 4,
    parameter int AW    = 32,
    parameter int RW    = 6,
    localparam int SW   = $clog2(SLOTS),
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    output logic          free_found,
    output logic [SW-1:0] free_slot,
    input  logic          wr_req,
    input  logic [RW-1:0] wr_dst,
    input  logic [2:0]    wr_size,
    input  logic          wr_float,
    input  logic          wr_reg_err,
    input  logic          wr_mem_err,
    input  logic [AW-1:0] wr_addr,
    input  logic          rel_valid,
    input  logic [SW-1:0] rel_slot,
    input  logic [SW-1:0] rd_sel,
    output logic          rd_valid,
    output logic          rd_addr_valid,
    output logic [RW-1:0] rd_dst,
    output logic [2:0]    rd_size,
    output logic [SW-1:0] rd_tag,
    output logic          rd_float,
    output logic          rd_reg_err,
    output logic          rd_mem_err,
    output logic [AW-1:0] rd_addr
);
    logic [SLOTS-1:0] ent_valid;
    logic [SLOTS-1:0] ent_av;
    logic [RW-1:0]    ent_dst   [SLOTS];
    logic [2:0]       ent_size  [SLOTS];
    logic [SW-1:0]    ent_tag   [SLOTS];
    logic [SLOTS-1:0] ent_float;
    logic [SLOTS-1:0] ent_rerr;
    logic [SLOTS-1:0] ent_merr;
    logic [AW-1:0]    ent_addr  [SLOTS];

    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if ((i < int'(cnt)) && !ent_valid[i]) begin
                free_found = 1'b1;
                free_slot  = SW'(i);
            end
        end
    end

    logic do_write;
    assign do_write = wr_req && free_found;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_av[g]    <= 1'b0;
                ent_dst[g]   <= '0;
                ent_size[g]  <= '0;
                ent_tag[g]   <= '0;
                ent_float[g] <= 1'b0;
                ent_rerr[g]  <= 1'b0;
                ent_merr[g]  <= 1'b0;
                ent_addr[g]  <= '0;
            end else begin
                if (rel_valid && rel_slot == SW'(g)) begin
                    ent_valid[g] <= 1'b0;
                    ent_av[g]    <= 1'b0;
                end
                if (do_write && free_slot == SW'(g)) begin
                    ent_valid[g] <= 1'b1;
                    ent_av[g]    <= 1'b1;
                    ent_dst[g]   <= wr_dst;
                    ent_size[g]  <= wr_size;
                    ent_tag[g]   <= SW'(g);
                    ent_float[g] <= wr_float;
                    ent_rerr[g]  <= wr_reg_err;
                    ent_merr[g]  <= wr_mem_err;
                    ent_addr[g]  <= wr_addr;
                end
            end
        end
    end

    always_comb begin
        rd_valid      = ent_valid[rd_sel];
        rd_addr_valid = ent_av[rd_sel];
        rd_dst        = ent_dst[rd_sel];
        rd_size       = ent_size[rd_sel];
        rd_tag        = ent_tag[rd_sel];
        rd_float      = ent_float[rd_sel];
        rd_reg_err    = ent_rerr[rd_sel];
        rd_mem_err    = ent_merr[rd_sel];
        rd_addr       = ent_addr[rd_sel];
    end

    // R8: a granted write lands in a slot that then reads valid
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> ent_valid[$past(free_slot)]);

    // R8: a slot at or above the implemented count is never chosen
    a_r8_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        free_found |-> (int'(free_slot) < int'(cnt)));

    // R9: a release without a colliding write frees the slot
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(do_write && free_slot == rel_slot)) |=> !ent_valid[$past(rel_slot)]);
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
    import slg_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NREG  = 64,
    parameter int SLOTS = 4,
    localparam int RW   = $clog2(NREG),
    localparam int SW   = $clog2(SLOTS),
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [RW-1:0]   req_base_sel,
    input  logic [AW-1:0]   req_base_val,
    input  logic            req_idx_en,
    input  logic [RW-1:0]   req_idx_sel,
    input  logic [AW-1:0]   req_idx_val,
    input  logic [AW-1:0]   req_imm,
    input  logic [2:0]      req_size,
    input  logic [RW-1:0]   req_dst,
    input  logic            req_float,
    input  logic            cfg_valid,
    input  logic            cfg_log_en,
    input  logic [CW-1:0]   cfg_slots,
    input  logic            rel_valid,
    input  logic [SW-1:0]   rel_slot,
    input  logic [SW-1:0]   rd_slot,
    output logic            done,
    output logic            proceed,
    output logic            log_err,
    output logic [NREG-1:0] gr_ne,
    output logic [NREG-1:0] fr_ne,
    output logic            rd_valid,
    output logic            rd_addr_valid,
    output logic [RW-1:0]   rd_dst,
    output logic [2:0]      rd_size,
    output logic [SW-1:0]   rd_tag,
    output logic            rd_float,
    output logic            rd_reg_err,
    output logic            rd_mem_err,
    output logic [AW-1:0]   rd_addr
);
    state_t state, state_nx;

    logic [RW-1:0] l_base_sel, l_idx_sel, l_dst;
    logic [AW-1:0] l_base_val, l_idx_val, l_imm;
    logic          l_idx_en, l_float;
    logic [2:0]    l_size;

    logic [AW-1:0] c_addr;
    logic          c_mem_f, c_reg_f, c_src;

    logic [AW-1:0] e_addr;
    logic          e_mem_f, e_reg_f, e_src;
    logic          fault_q;

    logic          free_found;
    logic [SW-1:0] free_slot;
    logic          log_on;
    logic          in_update;

    logic          proceed_q, log_err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_RESP);
        in_update = (state == ST_UPDATE);
        proceed   = proceed_q;
        log_err   = log_err_q;
        log_on    = cfg_valid && cfg_log_en;
        fault_q   = e_mem_f | e_reg_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_base_sel <= '0;
            l_idx_sel  <= '0;
            l_dst      <= '0;
            l_base_val <= '0;
            l_idx_val  <= '0;
            l_imm      <= '0;
            l_idx_en   <= 1'b0;
            l_float    <= 1'b0;
            l_size     <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            l_base_sel <= req_base_sel;
            l_idx_sel  <= req_idx_sel;
            l_dst      <= req_dst;
            l_base_val <= req_base_val;
            l_idx_val  <= req_idx_val;
            l_imm      <= req_imm;
            l_idx_en   <= req_idx_en;
            l_float    <= req_float;
            l_size     <= req_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_addr  <= '0;
            e_mem_f <= 1'b0;
            e_reg_f <= 1'b0;
            e_src   <= 1'b0;
        end else if (state == ST_EVAL) begin
            e_addr  <= c_addr;
            e_mem_f <= c_mem_f;
            e_reg_f <= c_reg_f;
            e_src   <= c_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proceed_q <= 1'b0;
            log_err_q <= 1'b0;
        end else if (in_update) begin
            proceed_q <= fault_q | ~e_src;
            log_err_q <= log_on & ~free_found;
        end
    end

    slg_addr_check #(.AW(AW), .RW(RW)) u_chk (
        .base_val  (l_base_val),
        .idx_val   (l_idx_val),
        .imm       (l_imm),
        .idx_en    (l_idx_en),
        .size      (l_size),
        .dst       (l_dst),
        .addr      (c_addr),
        .mem_fault (c_mem_f),
        .reg_fault (c_reg_f)
    );

    slg_ne_flags #(.NREG(NREG)) u_ne (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_float   (l_float),
        .q_a       (l_base_sel),
        .q_b       (l_idx_sel),
        .q_b_en    (l_idx_en),
        .src_flag  (c_src),
        .upd_en    (in_update),
        .upd_float (l_float),
        .upd_idx   (l_dst),
        .upd_val   (fault_q | e_src),
        .gr_vec    (gr_ne),
        .fr_vec    (fr_ne)
    );

    slg_log_table #(.SLOTS(SLOTS), .AW(AW), .RW(RW)) u_log (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt           (cfg_slots),
        .free_found    (free_found),
        .free_slot     (free_slot),
        .wr_req        (in_update && log_on),
        .wr_dst        (l_dst),
        .wr_size       (l_size),
        .wr_float      (l_float),
        .wr_reg_err    (e_reg_f),
        .wr_mem_err    (e_mem_f),
        .wr_addr       (e_addr),
        .rel_valid     (rel_valid),
        .rel_slot      (rel_slot),
        .rd_sel        (rd_slot),
        .rd_valid      (rd_valid),
        .rd_addr_valid (rd_addr_valid),
        .rd_dst        (rd_dst),
        .rd_size       (rd_size),
        .rd_tag        (rd_tag),
        .rd_float      (rd_float),
        .rd_reg_err    (rd_reg_err),
        .rd_mem_err    (rd_mem_err),
        .rd_addr       (rd_addr)
    );

    // R10: the response lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a response is followed by an idle cycle
    a_r10_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R4: a faulting load is never suppressed
    a_r4_fault_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_q) |-> proceed);

    // R5: a suppressed load had a tagged source and no fault
    a_r5_suppress_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !proceed) |-> (e_src && !fault_q));
endmodule

// File: tb/tb_spec_load_guard.sv
`timescale 1ns/1ps
module tb_spec_load_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_base_sel = '0;
    logic [31:0] req_base_val = '0;
    logic        req_idx_en = 1'b0;
    logic [5:0]  req_idx_sel = '0;
    logic [31:0] req_idx_val = '0;
    logic [31:0] req_imm = '0;
    logic [2:0]  req_size = '0;
    logic [5:0]  req_dst = '0;
    logic        req_float = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_log_en = 1'b0;
    logic [2:0]  cfg_slots = 3'd4;
    logic        rel_valid = 1'b0;
    logic [1:0]  rel_slot = '0;
    logic [1:0]  rd_slot = '0;
    logic        done, proceed, log_err;
    logic [63:0] gr_ne, fr_ne;
    logic        rd_valid, rd_addr_valid, rd_float, rd_reg_err, rd_mem_err;
    logic [5:0]  rd_dst;
    logic [2:0]  rd_size;
    logic [1:0]  rd_tag;
    logic [31:0] rd_addr;

    always #2.5 clk = ~clk;

    spec_load_guard dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base_sel(req_base_sel), .req_base_val(req_base_val),
        .req_idx_en(req_idx_en), .req_idx_sel(req_idx_sel),
        .req_idx_val(req_idx_val), .req_imm(req_imm), .req_size(req_size),
        .req_dst(req_dst), .req_float(req_float), .cfg_valid(cfg_valid),
        .cfg_log_en(cfg_log_en), .cfg_slots(cfg_slots), .rel_valid(rel_valid),
        .rel_slot(rel_slot), .rd_slot(rd_slot), .done(done), .proceed(proceed),
        .log_err(log_err), .gr_ne(gr_ne), .fr_ne(fr_ne), .rd_valid(rd_valid),
        .rd_addr_valid(rd_addr_valid), .rd_dst(rd_dst), .rd_size(rd_size),
        .rd_tag(rd_tag), .rd_float(rd_float), .rd_reg_err(rd_reg_err),
        .rd_mem_err(rd_mem_err), .rd_addr(rd_addr)
    );

    typedef struct packed {
        logic [5:0]  b;
        logic [31:0] bv;
        logic        ie;
        logic [5:0]  x;
        logic [31:0] xv;
        logic [31:0] im;
        logic [2:0]  sz;
        logic [5:0]  d;
        logic        f;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{6'd1,  32'h0000_1003, 1'b0, 6'd0, 32'h0,         32'h0, 3'd0, 6'd2,  1'b0},
        '{6'd1,  32'h0000_1001, 1'b0, 6'd0, 32'h0,         32'h0, 3'd1, 6'd3,  1'b0},
        '{6'd1,  32'h0000_0100, 1'b0, 6'd0, 32'h0,         32'h2, 3'd2, 6'd4,  1'b0},
        '{6'd1,  32'h0000_0040, 1'b0, 6'd0, 32'h0,         32'h0, 3'd3, 6'd5,  1'b0},
        '{6'd3,  32'h0000_0020, 1'b0, 6'd0, 32'h0,         32'h0, 3'd4, 6'd8,  1'b0},
        '{6'd1,  32'h0000_0030, 1'b0, 6'd0, 32'h0,         32'h0, 3'd4, 6'd10, 1'b0},
        '{6'd1,  32'h0000_0100, 1'b1, 6'd4, 32'h0000_0004, 32'h0, 3'd2, 6'd12, 1'b0},
        '{6'd1,  32'h0000_0100, 1'b0, 6'd4, 32'h0000_0004, 32'h0, 3'd2, 6'd12, 1'b0},
        '{6'd1,  32'h0000_0201, 1'b0, 6'd0, 32'h0,         32'h0, 3'd1, 6'd3,  1'b1},
        '{6'd3,  32'h0000_0200, 1'b0, 6'd0, 32'h0,         32'h0, 3'd0, 6'd7,  1'b1},
        '{6'd1,  32'h0000_0008, 1'b0, 6'd0, 32'h0,         32'h0, 3'd3, 6'd63, 1'b0},
        '{6'd1,  32'h0000_0007, 1'b0, 6'd0, 32'h0,         32'h0, 3'd5, 6'd20, 1'b0},
        '{6'd1,  32'hFFFF_FFF0, 1'b1, 6'd2, 32'h0000_0014, 32'h1, 3'd2, 6'd21, 1'b0}
    };

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] m_gr = '0;
    logic [63:0] m_fr = '0;
    int lat;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic mem_fault_m(input logic [31:0] a, input logic [2:0] sz);
        case (sz)
            3'd1: return a[0] != 1'b0;
            3'd2: return a[1:0] != 2'b0;
            3'd3: return a[2:0] != 3'b0;
            3'd4: return a[3:0] != 4'b0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reg_fault_m(input logic [5:0] d, input logic [2:0] sz);
        if (sz == 3'd3) return d[0];
        if (sz == 3'd4) return d[1:0] != 2'b0;
        return 1'b0;
    endfunction

    // Runs one load and compares proceed and both tag vectors with the model.
    task automatic run(input vec_t v, input string req);
        logic [63:0] sv;
        logic [31:0] a;
        logic src, flt, exp_p;
        sv = v.f ? m_fr : m_gr;
        a  = v.bv + (v.ie ? v.xv : v.im);
        src = sv[v.b] | (v.ie & sv[v.x]);
        flt = mem_fault_m(a, v.sz) | reg_fault_m(v.d, v.sz);
        exp_p = flt | ~src;
        if (v.f) m_fr[v.d] = flt | src;
        else     m_gr[v.d] = flt | src;
        @(negedge clk);
        req_base_sel = v.b; req_base_val = v.bv; req_idx_en = v.ie;
        req_idx_sel = v.x; req_idx_val = v.xv; req_imm = v.im;
        req_size = v.sz; req_dst = v.d; req_float = v.f; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            check(!req_ready, "R10 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R10 latency", 64'(lat), 64'd3);
        check(proceed == exp_p, {req, " proceed"}, 64'(proceed), 64'(exp_p));
        check(gr_ne == m_gr, {req, " gr_ne"}, gr_ne, m_gr);
        check(fr_ne == m_fr, {req, " fr_ne"}, fr_ne, m_fr);
        @(negedge clk);
        check(!done, "R10 done pulse", 64'(done), 64'd0);
    endtask

    function automatic vec_t mk(input logic [31:0] bv, input logic [2:0] sz, input logic [5:0] d, input logic f);
        vec_t v;
        v = '{6'd1, bv, 1'b0, 6'd0, 32'h0, 32'h0, sz, d, f};
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(gr_ne == 64'd0, "R10 reset gr", gr_ne, 64'd0);
        check(fr_ne == 64'd0, "R10 reset fr", fr_ne, 64'd0);
        check(req_ready && !done, "R10 reset handshake", {62'd0, req_ready, done}, 64'd2);
        check(!rd_valid, "R10 reset slot", 64'(rd_valid), 64'd0);

        // R1 R2 R3 R4 R5 R6: table walk, logging off
        for (int i = 0; i < NV; i++) run(VT[i], $sformatf("R1/R2/R3/R4/R5/R6 vec%0d", i));

        // R7: logging on, full count
        cfg_valid = 1'b1; cfg_log_en = 1'b1; cfg_slots = 3'd4;
        rd_slot = 2'd0;
        run(mk(32'h0000_1002, 3'd2, 6'd9, 1'b0), "R7 logA");
        check(rd_valid && rd_addr_valid, "R7 slot0 valid", {62'd0, rd_valid, rd_addr_valid}, 64'd3);
        check(rd_dst == 6'd9 && rd_size == 3'd2 && rd_tag == 2'd0, "R7 slot0 fields",
              {49'd0, rd_dst, rd_size, rd_tag}, {49'd0, 6'd9, 3'd2, 2'd0});
        check(!rd_float && !rd_reg_err && rd_mem_err, "R7 slot0 flags",
              {61'd0, rd_float, rd_reg_err, rd_mem_err}, 64'd1);
        check(rd_addr == 32'h0000_1002, "R7 slot0 addr", 64'(rd_addr), 64'h1002);
        check(!log_err, "R8 no err", 64'(log_err), 64'd0);

        rd_slot = 2'd1;
        run(mk(32'h0000_0040, 3'd3, 6'd5, 1'b1), "R7 logB");
        check(rd_valid && rd_float && rd_reg_err && !rd_mem_err && rd_tag == 2'd1, "R7 slot1 flags",
              {59'd0, rd_valid, rd_float, rd_reg_err, rd_mem_err, rd_tag[0]}, 64'h1D);

        // R8: count 2, table full
        cfg_slots = 3'd2; rd_slot = 2'd2;
        run(mk(32'h0000_0050, 3'd0, 6'd11, 1'b0), "R8 full");
        check(log_err, "R8 err raised", 64'(log_err), 64'd1);
        check(!rd_valid, "R8 slot2 untouched", 64'(rd_valid), 64'd0);

        // R9: release slot0, next log reuses it
        @(negedge clk);
        rel_slot = 2'd0; rel_valid = 1'b1;
        @(negedge clk);
        rel_valid = 1'b0; rd_slot = 2'd0;
        check(!rd_valid, "R9 released", 64'(rd_valid), 64'd0);
        run(mk(32'h0000_0060, 3'd0, 6'd14, 1'b0), "R9 reuse");
        check(rd_valid && rd_dst == 6'd14 && !log_err, "R9 slot0 reused",
              {56'd0, rd_valid, log_err, rd_dst}, {56'd0, 1'b1, 1'b0, 6'd14});
        rd_slot = 2'd1;
        #1;
        check(rd_dst == 6'd5, "R8 slot1 kept", 64'(rd_dst), 64'd5);

        // R7: logging gated by both bits
        cfg_slots = 3'd4; rd_slot = 2'd2;
        cfg_valid = 1'b0;
        run(mk(32'h0000_0070, 3'd0, 6'd15, 1'b0), "R7 gate valid");
        check(!rd_valid && !log_err, "R7 no log cfg_valid=0", {62'd0, rd_valid, log_err}, 64'd0);
        cfg_valid = 1'b1; cfg_log_en = 1'b0;
        run(mk(32'h0000_0070, 3'd0, 6'd16, 1'b0), "R7 gate en");
        check(!rd_valid, "R7 no log en=0", 64'(rd_valid), 64'd0);

        // R8: lowest free slot is 2 now
        cfg_log_en = 1'b1;
        run(mk(32'h0000_0081, 3'd1, 6'd17, 1'b0), "R8 lowest");
        check(rd_valid && rd_tag == 2'd2 && rd_dst == 6'd17, "R8 slot2 chosen",
              {55'd0, rd_valid, rd_tag, rd_dst}, {55'd0, 1'b1, 2'd2, 6'd17});

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule